// File: doc/BRIEF.md
# Multiplierless Symmetric Pulse-Shaping FIR

This block is a finite impulse response filter for root-raised-cosine pulse shaping on the transmit side, or for matched filtering on the receive side. It contains no multiplier. Each coefficient is a signed sum of at most two powers of two, and every product is built from shifts and additions or subtractions. The impulse response is symmetric about its centre tap. The two samples that share a coefficient are therefore added before the shift network, so only (taps+1)/2 coefficient products exist.

The digit tables are fixed at elaboration time. A parameter sets how many taps around the centre may use a second signed digit. Every outer tap uses exactly one signed power of two. Outer taps with the same exponent have their folded inputs summed first and are then shifted once as a group. Samples enter through a valid/ready handshake. In transmit use, an upsampling parameter makes the block insert zero samples after each accepted symbol, so that it emits one filtered output per oversampled slot. The wide sum is rounded and saturated to the output width.

Top module: `csd_pulse_fir`

## Requirements
- R1: A synchronous active-high reset clears the output-valid flag and the whole sample history. After reset `in_ready` is 1, and the first outputs reflect only samples accepted since the reset.
- R2: With OUT_SHIFT = 0, a single unit sample followed by zeros produces the integer coefficients h[0..N-1] on N consecutive outputs, where N = OS*SPAN+1, followed by zeros. The response is symmetric: h[k] = h[N-1-k].
- R3: Unique tap u (u = 0 outermost, u = (N-1)/2 centre) has two digits, `lo` and `hi`, each coded as sign 2'b01 = +1, 2'b11 = -1, 2'b00 = none, with weight 2^(10-exp) in integer units. Taps u >= (N+1)/2 - CENTRAL sum both digits. On the other taps the `hi` digit is ignored.
- R4: Every output equals the exact integer convolution of the coefficients with the last N history samples, including the sample accepted in that step. This holds for any input sequence.
- R5: The convolution sum S is rounded half up to S / 2^OUT_SHIFT, which is floor((S + 2^(OUT_SHIFT-1)) / 2^OUT_SHIFT) when OUT_SHIFT > 0. The result is then saturated to the range [-32768, 32767].
- R6: With UPS > 1, an accepted sample is followed by UPS-1 extra history steps that insert zeros. During those steps `in_ready` is 0. Each step yields one output, with `out_valid` high in the cycle after the step.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold their values, the history does not advance, and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block accepts the sample this cycle |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes the output |
| out_data | output | OUT_W | Rounded, saturated signed output |

## Verification
The bench builds two instances, each with SPAN 6, OS 8 and CENTRAL 13. One is a transmit instance with UPS 8 and OUT_SHIFT 6, which brings zero insertion, half-up rounding of negative halves and back-pressure into reach. The other is a receive instance with UPS 1 and OUT_SHIFT 0, whose impulse response exposes the raw integer coefficients and whose full-scale steps reach both saturation limits. The coefficient table given to both instances places a second digit on an outer tap, so that the digit budget becomes visible in the impulse response.

// File: rtl/csd_fir_pkg.sv
package csd_fir_pkg;

    // Smallest power of two weight is 2^-FRAC_BITS; coefficients are integers in those units.
    localparam int FRAC_BITS = 10;

    typedef enum logic [1:0] {
        SG_NONE = 2'b00,
        SG_POS  = 2'b01,
        SG_NEG  = 2'b11
    } csd_sign_e;

    typedef struct packed {
        csd_sign_e  sgn;
        logic [3:0] exp;
    } csd_digit_t;

    typedef struct packed {
        csd_digit_t hi;   // second digit, honoured on central taps only
        csd_digit_t lo;   // primary digit, present on every tap
    } csd_tap_t;

    localparam int DFLT_UNIQ = 25;

    function automatic csd_sign_e to_sign(input int s);
        if (s > 0) return SG_POS;
        if (s < 0) return SG_NEG;
        return SG_NONE;
    endfunction

    // Default table for span 6, oversampling 8: index 0 outermost, index 24 centre.
    function automatic csd_tap_t [DFLT_UNIQ-1:0] dflt_table();
        int s0 [DFLT_UNIQ] = '{-1,-1,-1, 1, 1, 1, 1, 1, 1,-1,-1,-1,-1,-1,-1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1};
        int e0 [DFLT_UNIQ] = '{ 7, 8, 9, 8, 7, 6, 6, 6, 7, 8, 6, 5, 5, 5, 6, 6, 4, 3, 3, 2, 2, 1, 1, 1, 1};
        int s1 [DFLT_UNIQ] = '{ 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0,-1, 1, 1, 1, 1, 1, 1,-1, 1,-1,-1, 1, 1};
        int e1 [DFLT_UNIQ] = '{ 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 7, 8, 9, 8, 6, 6, 5, 6, 5, 3, 4, 4, 3};
        csd_tap_t [DFLT_UNIQ-1:0] t;
        for (int u = 0; u < DFLT_UNIQ; u++) begin
            t[u].lo.sgn = to_sign(s0[u]);
            t[u].lo.exp = 4'(e0[u]);
            t[u].hi.sgn = to_sign(s1[u]);
            t[u].hi.exp = 4'(e1[u]);
        end
        return t;
    endfunction

    localparam csd_tap_t [DFLT_UNIQ-1:0] DFLT_COEF = dflt_table();

endpackage

// File: rtl/csd_fold_line.sv
module csd_fold_line #(
    parameter int IN_W  = 12,
    parameter int NTAPS = 49,
    localparam int NUNIQ = (NTAPS + 1) / 2,
    localparam int PW    = IN_W + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       step,
    input  logic [IN_W-1:0]            din,
    output logic [NUNIQ-1:0][PW-1:0]   pre
);
    logic [NTAPS-1:0][IN_W-1:0] hist;
    logic [NTAPS-1:0][IN_W-1:0] win;

    // Window as it will be after this step: newest sample at index 0.
    always_comb begin
        win[0] = din;
        for (int k = 1; k < NTAPS; k++) win[k] = hist[k-1];
    end

    always_ff @(posedge clk) begin
        if (rst)       hist <= '0;
        else if (step) hist <= win;
    end

    // Mirrored taps share a coefficient, so their samples are summed first.
    for (genvar u = 0; u < NUNIQ; u++) begin : g_fold
        if (u == NUNIQ - 1) begin : g_mid
            assign pre[u] = {win[u][IN_W-1], win[u]};
        end else begin : g_pair
            assign pre[u] = {win[u][IN_W-1], win[u]} + {win[NTAPS-1-u][IN_W-1], win[NTAPS-1-u]};
        end
    end
endmodule

// File: rtl/csd_shift_sum.sv
module csd_shift_sum
    import csd_fir_pkg::*;
#(
    parameter int IN_W    = 12,
    parameter int NTAPS   = 49,
    parameter int CENTRAL = 13,
    parameter int ACC_W   = 31,
    localparam int NUNIQ  = (NTAPS + 1) / 2,
    localparam int PW     = IN_W + 1,
    localparam int NOUTER = NUNIQ - CENTRAL,
    parameter csd_tap_t [NUNIQ-1:0] COEF = DFLT_COEF
) (
    input  logic [NUNIQ-1:0][PW-1:0] pre,
    output logic signed [ACC_W-1:0]  acc
);
    logic signed [ACC_W-1:0] grp;

    function automatic logic signed [ACC_W-1:0] sx(input logic [PW-1:0] v);
        return {{(ACC_W-PW){v[PW-1]}}, v};
    endfunction

    function automatic logic signed [ACC_W-1:0] term(input logic [PW-1:0] v, input csd_digit_t d);
        logic signed [ACC_W-1:0] m;
        if (int'(d.exp) > FRAC_BITS) return '0;
        m = sx(v) <<< (FRAC_BITS - int'(d.exp));
        if (d.sgn == SG_POS) return m;
        if (d.sgn == SG_NEG) return -m;
        return '0;
    endfunction

    always_comb begin
        acc = '0;
        grp = '0;
        // Outer taps: single digit each; taps with equal exponent share one shifter.
        for (int e = 0; e <= FRAC_BITS; e++) begin
            grp = '0;
            for (int u = 0; u < NOUTER; u++) begin
                if (int'(COEF[u].lo.exp) == e) begin
                    if (COEF[u].lo.sgn == SG_POS)      grp = grp + sx(pre[u]);
                    else if (COEF[u].lo.sgn == SG_NEG) grp = grp - sx(pre[u]);
                end
            end
            acc = acc + (grp <<< (FRAC_BITS - e));
        end
        // Central taps: two signed digits each.
        for (int u = NOUTER; u < NUNIQ; u++) begin
            acc = acc + term(pre[u], COEF[u].lo) + term(pre[u], COEF[u].hi);
        end
    end
endmodule

// File: rtl/csd_round_sat.sv
module csd_round_sat #(
    parameter int ACC_W     = 31,
    parameter int OUT_W     = 16,
    parameter int OUT_SHIFT = 6
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic [OUT_W-1:0]        y
);
    localparam logic signed [ACC_W-1:0] MAXV = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MINV = {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [ACC_W-1:0] scaled;

    if (OUT_SHIFT == 0) begin : g_noshift
        assign scaled = acc;
    end else begin : g_shift
        localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (OUT_SHIFT - 1);
        assign scaled = (acc + HALF) >>> OUT_SHIFT;
    end

    always_comb begin
        if (scaled > MAXV)      y = MAXV[OUT_W-1:0];
        else if (scaled < MINV) y = MINV[OUT_W-1:0];
        else                    y = scaled[OUT_W-1:0];
    end
endmodule

// File: rtl/csd_pulse_fir.sv
module csd_pulse_fir
    import csd_fir_pkg::*;
#(
    parameter int IN_W      = 12,
    parameter int OUT_W     = 16,
    parameter int SPAN      = 6,
    parameter int OS        = 8,
    parameter int UPS       = 8,
    parameter int CENTRAL   = 13,
    parameter int OUT_SHIFT = 6,
    localparam int NTAPS    = OS * SPAN + 1,
    localparam int NUNIQ    = (NTAPS + 1) / 2,
    parameter csd_tap_t [NUNIQ-1:0] COEF = DFLT_COEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data
);
    localparam int PW    = IN_W + 1;
    localparam int ACC_W = PW + FRAC_BITS + $clog2(NTAPS) + 2;
    localparam int PHW   = (UPS > 1) ? $clog2(UPS) : 1;

    logic [PHW-1:0]            phase;
    logic                      at_sym, room, adv;
    logic [IN_W-1:0]           din;
    logic [NUNIQ-1:0][PW-1:0]  pre;
    logic signed [ACC_W-1:0]   acc;
    logic [OUT_W-1:0]          y;

    assign at_sym   = (phase == '0);
    assign room     = !out_valid || out_ready;
    assign in_ready = at_sym && room;
    assign adv      = room && (at_sym ? in_valid : 1'b1);
    assign din      = at_sym ? in_data : '0;

    csd_fold_line #(.IN_W(IN_W), .NTAPS(NTAPS)) line_i (
        .clk(clk), .rst(rst), .step(adv), .din(din), .pre(pre)
    );

    csd_shift_sum #(.IN_W(IN_W), .NTAPS(NTAPS), .CENTRAL(CENTRAL), .ACC_W(ACC_W), .COEF(COEF)) sum_i (
        .pre(pre), .acc(acc)
    );

    csd_round_sat #(.ACC_W(ACC_W), .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT)) rnd_i (
        .acc(acc), .y(y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (adv) begin
            phase     <= (phase == PHW'(UPS - 1)) ? '0 : phase + 1'b1;
            out_valid <= 1'b1;
            out_data  <= y;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/csd_pulse_fir_chk.sv
module csd_pulse_fir_chk #(
    parameter int OUT_W = 16,
    parameter int UPS   = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_data
);
    p_reset_r1: assert property (@(posedge clk) rst |=> !out_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_room_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    p_accept_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    if (UPS > 1) begin : g_stuff
        p_stuff_r6: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_ready) |=> !in_ready);
    end
endmodule

bind csd_pulse_fir csd_pulse_fir_chk #(.OUT_W(OUT_W), .UPS(UPS)) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/csd_pulse_fir_tb_top.sv
`timescale 1ns/1ps
module csd_pulse_fir_tb_top;
    import csd_fir_pkg::*;

    localparam int NT = 49;
    localparam int NU = 25;
    localparam int NCEN = 13;

    // Bench coefficient digits; outer tap 3 carries a second digit that must be ignored.
    localparam int S0 [NU] = '{-1,-1,-1, 1, 1, 1, 1, 1, 1,-1,-1,-1,-1,-1,-1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1};
    localparam int E0 [NU] = '{ 7, 8, 9, 8, 7, 6, 6, 6, 7, 8, 6, 5, 5, 5, 6, 6, 4, 3, 3, 2, 2, 1, 1, 1, 1};
    localparam int S1 [NU] = '{ 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0,-1, 1, 1, 1, 1, 1, 1,-1, 1,-1,-1, 1, 1};
    localparam int E1 [NU] = '{ 0, 0, 0, 9, 0, 0, 0, 0, 0, 0, 0, 0, 7, 8, 9, 8, 6, 6, 5, 6, 5, 3, 4, 4, 3};

    function automatic csd_tap_t [NU-1:0] build();
        csd_tap_t [NU-1:0] t;
        for (int u = 0; u < NU; u++) begin
            t[u].lo.sgn = (S0[u] > 0) ? SG_POS : (S0[u] < 0) ? SG_NEG : SG_NONE;
            t[u].lo.exp = 4'(E0[u]);
            t[u].hi.sgn = (S1[u] > 0) ? SG_POS : (S1[u] < 0) ? SG_NEG : SG_NONE;
            t[u].hi.exp = 4'(E1[u]);
        end
        return t;
    endfunction
    localparam csd_tap_t [NU-1:0] TB_COEF = build();

    logic clk = 0;
    always #5 clk = ~clk;
    logic rst;

    logic tx_iv, tx_ir, tx_ov, tx_or;
    logic [11:0] tx_id;
    logic [15:0] tx_od;
    logic rx_iv, rx_ir, rx_ov, rx_or;
    logic [11:0] rx_id;
    logic [15:0] rx_od;

    csd_pulse_fir #(.UPS(8), .OUT_SHIFT(6), .CENTRAL(NCEN), .COEF(TB_COEF)) dut_i (
        .clk(clk), .rst(rst), .in_valid(tx_iv), .in_ready(tx_ir), .in_data(tx_id),
        .out_valid(tx_ov), .out_ready(tx_or), .out_data(tx_od));

    csd_pulse_fir #(.UPS(1), .OUT_SHIFT(0), .CENTRAL(NCEN), .COEF(TB_COEF)) rx_i (
        .clk(clk), .rst(rst), .in_valid(rx_iv), .in_ready(rx_ir), .in_data(rx_id),
        .out_valid(rx_ov), .out_ready(rx_or), .out_data(rx_od));

    int hcoef [NT];
    int hist_tx [NT];
    int hist_rx [NT];
    int n_chk = 0, n_fail = 0;

    // R3: value from digits; outer taps use the primary digit only.
    function automatic int digit_val(int s, int e);
        return s * (1 << (10 - e));
    endfunction

    function automatic int uniq_val(int u);
        int v = digit_val(S0[u], E0[u]);
        if (u >= NU - NCEN) v += digit_val(S1[u], E1[u]);
        return v;
    endfunction

    // R4/R5 reference model.
    function automatic int model(bit rx);
        longint acc = 0;
        int sh = rx ? 0 : 6;
        for (int k = 0; k < NT; k++) acc += longint'(hcoef[k]) * longint'(rx ? hist_rx[k] : hist_tx[k]);
        if (sh > 0) acc = (acc + (longint'(1) <<< (sh - 1))) >>> sh;
        if (acc > 32767) acc = 32767;
        if (acc < -32768) acc = -32768;
        return int'(acc);
    endfunction

    function automatic void push_tx(int x);
        for (int k = NT - 1; k > 0; k--) hist_tx[k] = hist_tx[k-1];
        hist_tx[0] = x;
    endfunction

    function automatic void push_rx(int x);
        for (int k = NT - 1; k > 0; k--) hist_rx[k] = hist_rx[k-1];
        hist_rx[0] = x;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; tx_iv = 0; rx_iv = 0; tx_or = 1; rx_or = 1; tx_id = '0; rx_id = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        for (int k = 0; k < NT; k++) begin hist_tx[k] = 0; hist_rx[k] = 0; end
        @(negedge clk);
        chk(!tx_ov, "R1 tx out_valid after reset", tx_ov, 0);
        chk(!rx_ov, "R1 rx out_valid after reset", rx_ov, 0);
        chk(tx_ir, "R1 tx in_ready after reset", tx_ir, 1);
    endtask

    // Receive instance: one sample, one output in the next cycle.
    task automatic rx_push(int x, string req);
        rx_iv = 1; rx_id = 12'(x);
        @(posedge clk);
        @(negedge clk);
        rx_iv = 0;
        push_rx(x);
        chk(rx_ov, req, rx_ov, 1);
        chk($signed(rx_od) == model(1), req, $signed(rx_od), model(1));
    endtask

    task automatic test_rx_impulse(string req);
        for (int i = 0; i < NT + 2; i++) begin
            rx_iv = 1; rx_id = (i == 0) ? 12'd1 : 12'd0;
            @(posedge clk);
            @(negedge clk);
            rx_iv = 0;
            push_rx(i == 0 ? 1 : 0);
            if (i == 3 || i == NT - 4)
                chk($signed(rx_od) == ((i < NT) ? hcoef[i] : 0), "R3 outer second digit ignored", $signed(rx_od), hcoef[i]);
            else
                chk($signed(rx_od) == ((i < NT) ? hcoef[i] : 0), req, $signed(rx_od), (i < NT) ? hcoef[i] : 0);
        end
    endtask

    task automatic test_rx_random(int n);
        for (int i = 0; i < n; i++) rx_push(int'($urandom_range(4095)) - 2048, "R4 rx random convolution");
    endtask

    task automatic test_rx_saturate();
        for (int i = 0; i < NT; i++) rx_push(2047, "R5 rx positive step");
        chk($signed(rx_od) == 32767, "R5 positive saturation", $signed(rx_od), 32767);
        for (int i = 0; i < NT; i++) rx_push(-2048, "R5 rx negative step");
        chk($signed(rx_od) == -32768, "R5 negative saturation", $signed(rx_od), -32768);
    endtask

    task automatic test_rx_reset_clears();
        test_rx_random(10);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        for (int k = 0; k < NT; k++) begin hist_tx[k] = 0; hist_rx[k] = 0; end
        chk(!rx_ov, "R1 out_valid cleared by reset", rx_ov, 0);
        test_rx_impulse("R1 history cleared by reset");
    endtask

    // Transmit instance: one symbol, then UPS-1 zero-inserted outputs.
    task automatic tx_symbol(int x, string req);
        tx_iv = 1; tx_id = 12'(x);
        @(posedge clk);
        @(negedge clk);
        tx_iv = 0;
        push_tx(x);
        chk(tx_ov && $signed(tx_od) == model(0), req, $signed(tx_od), model(0));
        for (int p = 1; p < 8; p++) begin
            chk(!tx_ir, "R6 in_ready low during zero insertion", tx_ir, 0);
            @(posedge clk);
            @(negedge clk);
            push_tx(0);
            chk(tx_ov && $signed(tx_od) == model(0), "R6 zero-inserted output", $signed(tx_od), model(0));
        end
        chk(tx_ir, "R6 in_ready back after UPS outputs", tx_ir, 1);
    endtask

    task automatic test_tx_impulse();
        tx_symbol(1, "R5 tx impulse rounding");
        for (int i = 0; i < 7; i++) tx_symbol(0, "R5 tx impulse tail rounding");
    endtask

    task automatic test_tx_random(int n);
        for (int i = 0; i < n; i++) tx_symbol(int'($urandom_range(4095)) - 2048, "R4 tx random symbols");
    endtask

    task automatic test_tx_stall();
        logic [15:0] held;
        @(negedge clk);
        tx_or = 0; tx_iv = 1; tx_id = 12'd1500;
        @(posedge clk);
        @(negedge clk);
        tx_iv = 0;
        push_tx(1500);
        held = tx_od;
        chk(tx_ov && $signed(tx_od) == model(0), "R7 first output before stall", $signed(tx_od), model(0));
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk(tx_ov, "R7 valid held", tx_ov, 1);
            chk(tx_od == held, "R7 data held", tx_od, held);
            chk(!tx_ir, "R7 in_ready low while stalled", tx_ir, 0);
        end
        tx_or = 1;
        for (int p = 1; p < 8; p++) begin
            @(posedge clk);
            @(negedge clk);
            push_tx(0);
            chk(tx_ov && $signed(tx_od) == model(0), "R7 no sample lost after stall", $signed(tx_od), model(0));
        end
    endtask

    initial begin
        for (int k = 0; k < NT; k++) hcoef[k] = uniq_val((k < NU) ? k : NT - 1 - k);
        rst = 1; tx_iv = 0; rx_iv = 0; tx_or = 1; rx_or = 1; tx_id = '0; rx_id = '0;
        do_reset();
        // R2: symmetry of the bench table is what the impulse test expects.
        chk(hcoef[0] == hcoef[NT-1], "R2 symmetric coefficients", hcoef[NT-1], hcoef[0]);
        test_rx_impulse("R2 impulse equals coefficients");
        test_rx_random(120);
        test_rx_saturate();
        test_rx_reset_clears();
        test_tx_impulse();
        test_tx_random(40);
        test_tx_stall();
        for (int i = 0; i < 8; i++) tx_symbol(-2048, "R4 tx negative step");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule